// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler and Watchdog

This block is an 8-bit timer/counter with one 8-bit prescaler that it shares with a watchdog. An owner bit in an option byte decides where the prescaler sits. When the timer owns it, the prescaler divides the timer's input. When the watchdog owns it, the prescaler divides the watchdog's base overflows, and the timer then counts every input event.

The timer's input is either an instruction-cycle tick or an external pin. The tick is generated inside the block as one pulse every four system clocks. The pin is counted on an edge that the option byte selects. It is resynchronized, and the timer sees a level change only when two samples, taken at the middle and at the end of an instruction cycle, agree.

When the timer rolls over, a sticky overflow flag is set. The flag is gated with an enable input to form the interrupt request. The watchdog counts ticks from an external slow-oscillator input and emits a one-clock reset pulse when it expires. A clear-watchdog strobe restarts the watchdog. A sleep input freezes the timer.

Top module: `sps_shared_timer`

## Requirements
- R1: While reset is held, the option byte reads FFh, the timer reads 00h, and the overflow flag, the interrupt request and the watchdog reset output are all 0.
- R2: Option byte fields: bit 5 selects the timer source (0 = instruction-cycle tick, one every 4 clocks; 1 = pin). Bit 4 selects the pin edge (0 = rising, 1 = falling). Bit 3 selects the prescaler owner (0 = timer, 1 = watchdog). Bits 2:0 hold the ratio code PS. With the tick source and the watchdog as owner, the timer advances once per instruction cycle.
- R3: When the timer owns the prescaler, the timer advances once per 2^(PS+1) input events (PS=0 gives 1:2, PS=2 gives 1:8).
- R4: A timer write loads the value and wins over a same-cycle increment. Counting then holds for two instruction cycles. If the timer owns the prescaler, the write also clears the prescaler.
- R5: The overflow flag is set on every FFh to 00h rollover and stays set until the clear input is pulsed. A rollover wins over a same-cycle clear. The interrupt request equals flag AND enable.
- R6: In pin mode the timer counts the selected pin edge after resynchronization. When the timer owns the prescaler, the timer counts the prescaler output instead of the pin.
- R7: While sleep is high, the timer value does not change.
- R8: The watchdog base counter is 8 bits wide and advances on each watchdog tick. With the timer as owner, a reset pulse one clock wide follows every 256 ticks. With the watchdog as owner, the period is 256·2^PS ticks.
- R9: The clear-watchdog strobe zeroes the base counter. If the watchdog owns the prescaler, the strobe clears the prescaler too.
- R10: If the owner bit is switched to the watchdog while the prescaler still holds a count left by the timer, the first watchdog expiry comes early. If the prescaler was cleared by a timer write before the switch, the full period applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write value |
| opt_wr | input | 1 | Option byte write strobe |
| opt_wdata | input | 8 | Option byte write value |
| ovf_clr | input | 1 | Overflow flag clear |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ext_pin | input | 1 | External count pin (asynchronous) |
| sleep | input | 1 | Freezes the timer while high |
| wdt_tick | input | 1 | Watchdog oscillator tick, one clock wide |
| wdt_clr | input | 1 | Clear-watchdog strobe |
| tmr_value | output | 8 | Current timer value |
| opt_value | output | 8 | Current option byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The overflow flag can be set by a rollover and cleared by software in the same clock cycle. To provoke this, the bench holds the clear input high for the whole window in which the timer is loaded with FFh and rolls over. The set must win, so the flag is expected high for exactly one sampled cycle and low again afterwards. A timer write and a counting event can also coincide. That case is judged by the written value appearing unchanged and the two-cycle hold that follows it.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int OPT_W = 8;
  localparam logic [OPT_W-1:0] OPT_RESET = 8'hFF;
  localparam int BIT_SRC   = 5;
  localparam int BIT_EDGE  = 4;
  localparam int BIT_OWNER = 3;
  localparam int RATIO_LSB = 0;
  localparam int RATIO_W   = 3;

  typedef enum logic { OWN_TIMER = 1'b0, OWN_WDOG = 1'b1 } owner_e;
  typedef enum logic { SRC_CYCLE = 1'b0, SRC_PIN = 1'b1 } source_e;
endpackage

// File: rtl/sps_cycle_sync.sv
module sps_cycle_sync #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_edge,
  input  logic use_tap,
  input  logic tap_lvl,
  output logic tick,
  output logic pin_rise,
  output logic ext_evt
);
  localparam int PHW = (PHASES > 2) ? $clog2(PHASES) : 1;
  localparam logic [PHW-1:0] PH_LAST = PHW'(PHASES - 1);
  localparam logic [PHW-1:0] PH_MID  = PHW'(PHASES / 2 - 1);

  logic [PHW-1:0] ph_q, ph_d;
  logic [1:0]     meta_q, meta_d;
  logic           pinx_d_q, samp_a_q, samp_a_d, lvl_q, lvl_d;
  logic           pin_x, lvl_in, agree, mid;

  always_comb begin
    pin_x    = meta_q[1] ^ fall_edge;
    lvl_in   = use_tap ? tap_lvl : pin_x;
    tick     = (ph_q == PH_LAST);
    mid      = (ph_q == PH_MID);
    agree    = (lvl_in == samp_a_q);
    ph_d     = tick ? '0 : ph_q + PHW'(1);
    meta_d   = {meta_q[0], pin};
    samp_a_d = mid ? lvl_in : samp_a_q;
    lvl_d    = (tick && agree) ? lvl_in : lvl_q;
    ext_evt  = tick & agree & lvl_in & ~lvl_q;
    pin_rise = pin_x & ~pinx_d_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= '0;
      meta_q   <= '0;
      pinx_d_q <= 1'b0;
      samp_a_q <= 1'b0;
      lvl_q    <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      meta_q   <= meta_d;
      pinx_d_q <= pin_x;
      samp_a_q <= samp_a_d;
      lvl_q    <= lvl_d;
    end
  end

  // R2: the cycle tick is a single-clock pulse
  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R6: an accepted pin event leaves the synchronized level high
  assert_sync_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> lvl_q);
endmodule

// File: rtl/sps_prescaler.sv
module sps_prescaler #(
  parameter int PW = 8,
  parameter int EW = $clog2(PW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          clr,
  input  logic [EW-1:0] expo,
  output logic          carry,
  output logic          tap
);
  logic [PW-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    mask = '0;
    tap  = 1'b0;
    for (int i = 0; i < PW; i++) begin
      if (EW'(i) < expo)       mask[i] = 1'b1;
      if (expo == EW'(i + 1))  tap     = cnt_q[i];
    end
    carry = inc & (&(cnt_q | ~mask));
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + PW'(1);
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4 / R9: a clear leaves the prescaler empty
  assert_presc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/sps_timer.sv
module sps_timer #(
  parameter int TW   = 8,
  parameter int HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          sleep,
  input  logic          wr,
  input  logic [TW-1:0] wdata,
  input  logic          evt,
  input  logic          flag_clr,
  output logic [TW-1:0] value,
  output logic          flag,
  output logic          busy
);
  localparam int HW = $clog2(HOLD + 1);

  logic [TW-1:0] val_q, val_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          flag_q, flag_d, step_en, wrap;

  always_comb begin
    busy    = (hold_q != '0);
    step_en = evt & ~busy & ~sleep;
    wrap    = step_en & (val_q == '1) & ~wr;
    if (wr)           val_d = wdata;
    else if (step_en) val_d = val_q + TW'(1);
    else              val_d = val_q;
    if (wr)                hold_d = HW'(HOLD);
    else if (tick && busy) hold_d = hold_q - HW'(1);
    else                   hold_d = hold_q;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      hold_q <= '0;
      flag_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      hold_q <= hold_d;
      flag_q <= flag_d;
    end
  end

  assign value = val_q;
  assign flag  = flag_q;

  assert_write_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (value == $past(wdata)));
  assert_hold_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr) |=> $stable(value));
  assert_sleep_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wr) |=> $stable(value));
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/sps_watchdog.sv
module sps_watchdog #(
  parameter int WW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wtick,
  input  logic wclr,
  input  logic to_wdog,
  input  logic presc_carry,
  output logic base_ovf,
  output logic rst_pulse
);
  logic [WW-1:0] base_q, base_d;
  logic          rst_q, fire;

  always_comb begin
    base_ovf = wtick & ~wclr & (base_q == '1);
    fire     = to_wdog ? presc_carry : base_ovf;
    if (wclr)       base_d = '0;
    else if (wtick) base_d = base_q + WW'(1);
    else            base_d = base_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      rst_q  <= fire;
    end
  end

  assign rst_pulse = rst_q;

  assert_base_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wclr |=> (base_q == '0));
  assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
endmodule

// File: rtl/sps_shared_timer.sv
module sps_shared_timer
  import sps_pkg::*;
#(
  parameter int TW     = 8,
  parameter int PW     = 8,
  parameter int WW     = 8,
  parameter int PHASES = 4,
  parameter int HOLD   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_wr,
  input  logic [TW-1:0]    tmr_wdata,
  input  logic             opt_wr,
  input  logic [OPT_W-1:0] opt_wdata,
  input  logic             ovf_clr,
  input  logic             ovf_ie,
  input  logic             ext_pin,
  input  logic             sleep,
  input  logic             wdt_tick,
  input  logic             wdt_clr,
  output logic [TW-1:0]    tmr_value,
  output logic [OPT_W-1:0] opt_value,
  output logic             ovf_flag,
  output logic             irq,
  output logic             wdt_rst
);
  localparam int EW = $clog2(PW + 1);

  logic [OPT_W-1:0] opt_q, opt_d;
  owner_e           owner;
  source_e          source;
  logic [EW-1:0]    expo;
  logic             tick, pin_rise, ext_evt, busy, base_ovf;
  logic             presc_inc, presc_clr, carry, tap, use_tap, tmr_evt;

  always_comb begin
    opt_d  = opt_wr ? opt_wdata : opt_q;
    owner  = owner_e'(opt_q[BIT_OWNER]);
    source = source_e'(opt_q[BIT_SRC]);
    expo   = EW'(opt_q[RATIO_LSB +: RATIO_W]) + ((owner == OWN_TIMER) ? EW'(1) : EW'(0));
    use_tap = (source == SRC_PIN) && (owner == OWN_TIMER);
    if (owner == OWN_WDOG) begin
      presc_inc = base_ovf;
      presc_clr = wdt_clr;
    end else begin
      presc_inc = ~busy & ~sleep & ((source == SRC_PIN) ? pin_rise : tick);
      presc_clr = tmr_wr;
    end
    if (source == SRC_PIN)      tmr_evt = ext_evt;
    else if (owner == OWN_WDOG) tmr_evt = tick;
    else                        tmr_evt = carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) opt_q <= OPT_RESET;
    else        opt_q <= opt_d;
  end

  sps_cycle_sync #(.PHASES(PHASES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .fall_edge(opt_q[BIT_EDGE]),
    .use_tap(use_tap), .tap_lvl(tap), .tick(tick), .pin_rise(pin_rise),
    .ext_evt(ext_evt));

  sps_prescaler #(.PW(PW), .EW(EW)) u_presc (
    .clk(clk), .rst_n(rst_n), .inc(presc_inc), .clr(presc_clr),
    .expo(expo), .carry(carry), .tap(tap));

  sps_timer #(.TW(TW), .HOLD(HOLD)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep(sleep), .wr(tmr_wr),
    .wdata(tmr_wdata), .evt(tmr_evt), .flag_clr(ovf_clr),
    .value(tmr_value), .flag(ovf_flag), .busy(busy));

  sps_watchdog #(.WW(WW)) u_wdog (
    .clk(clk), .rst_n(rst_n), .wtick(wdt_tick), .wclr(wdt_clr),
    .to_wdog(owner == OWN_WDOG), .presc_carry(carry),
    .base_ovf(base_ovf), .rst_pulse(wdt_rst));

  assign opt_value = opt_q;
  assign irq       = ovf_flag & ovf_ie;

  // R2: option byte writes take effect on the next cycle
  assert_opt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    opt_wr |=> (opt_value == $past(opt_wdata)));
  // R5: no request without the flag
  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);
endmodule

// File: tb/sps_shared_timer_tb.sv
`timescale 1ns/1ps
module sps_shared_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tmr_wr, opt_wr, ovf_clr, ovf_ie, ext_pin, sleep, wdt_tick, wdt_clr;
  logic [7:0] tmr_wdata, opt_wdata;
  logic [7:0] tmr_value, opt_value;
  logic       ovf_flag, irq, wdt_rst;

  int n_run  = 0;
  int n_fail = 0;
  int rst_seen = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sps_shared_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
    .opt_wr(opt_wr), .opt_wdata(opt_wdata), .ovf_clr(ovf_clr), .ovf_ie(ovf_ie),
    .ext_pin(ext_pin), .sleep(sleep), .wdt_tick(wdt_tick), .wdt_clr(wdt_clr),
    .tmr_value(tmr_value), .opt_value(opt_value), .ovf_flag(ovf_flag),
    .irq(irq), .wdt_rst(wdt_rst));

  always @(posedge clk) if (rst_n && wdt_rst) rst_seen++;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_opt(input logic [7:0] v);
    opt_wdata = v; opt_wr = 1'b1; step(1); opt_wr = 1'b0;
  endtask

  task automatic wr_tmr(input logic [7:0] v);
    tmr_wdata = v; tmr_wr = 1'b1; step(1); tmr_wr = 1'b0;
  endtask

  task automatic wd_clear();
    wdt_clr = 1'b1; step(1); wdt_clr = 1'b0;
  endtask

  task automatic wd_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      wdt_tick = 1'b1; step(1); wdt_tick = 1'b0; step(1);
    end
    step(3);
  endtask

  task automatic t_reset();
    chk("R1 opt", opt_value, 8'hFF);
    chk("R1 tmr", tmr_value, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wdt_rst", wdt_rst, 0);
  endtask

  task automatic t_cycle_count();
    wr_opt(8'h08);
    ext_pin = 1'b0;
    wr_tmr(8'h20); step(4 * 12);
    chk("R2 one per cycle", tmr_value, 8'h2A);
    wr_tmr(8'h05); step(8);
    chk("R4 hold after write", tmr_value, 8'h05);
    step(4);
    chk("R4 resume after hold", tmr_value, 8'h06);
  endtask

  task automatic t_ratio();
    wr_opt(8'h00);
    wr_tmr(8'd10); step(4 * 12);
    chk("R3 ratio 1:2", tmr_value, 8'd15);
    wr_opt(8'h02);
    wr_tmr(8'd0); step(4 * 42);
    chk("R3 ratio 1:8", tmr_value, 8'd5);
    wr_tmr(8'd0); step(4 * 8);
    wr_tmr(8'd0); step(4 * 8);
    chk("R4 write clears prescaler", tmr_value, 8'd0);
  endtask

  task automatic t_flag();
    int highs;
    wr_opt(8'h08);
    ovf_ie = 1'b0;
    wr_tmr(8'hFE); step(4 * 4);
    chk("R5 rollover value", tmr_value, 8'h00);
    chk("R5 flag set", ovf_flag, 1);
    chk("R5 irq masked", irq, 0);
    ovf_ie = 1'b1; step(1);
    chk("R5 irq enabled", irq, 1);
    step(4 * 3);
    chk("R5 flag sticky", ovf_flag, 1);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
    chk("R5 flag cleared", ovf_flag, 0);
    chk("R5 irq dropped", irq, 0);
    ovf_clr = 1'b1;
    wr_tmr(8'hFF);
    highs = 0;
    for (int i = 0; i < 4 * 6; i++) begin
      step(1);
      if (ovf_flag) highs++;
    end
    ovf_clr = 1'b0;
    chk("R5 set beats clear", highs, 1);
    ovf_ie = 1'b0;
  endtask

  task automatic t_sleep();
    wr_opt(8'h08);
    wr_tmr(8'd0);
    sleep = 1'b1; step(40);
    chk("R7 frozen in sleep", tmr_value, 0);
    sleep = 1'b0; step(4 * 5);
    chk("R7 counts after wake", tmr_value, 5);
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1'b1; step(32); ext_pin = 1'b0; step(32);
    end
  endtask

  task automatic t_pin();
    wr_opt(8'h28); step(20);
    wr_tmr(8'd0); step(20);
    ext_pin = 1'b1; step(30);
    chk("R6 rising edge counted", tmr_value, 1);
    ext_pin = 1'b0; step(32);
    pin_pulses(2);
    chk("R6 rising pulses", tmr_value, 3);
    wr_opt(8'h38); step(20);
    wr_tmr(8'd0); step(20);
    ext_pin = 1'b1; step(30);
    chk("R6 falling mode ignores rise", tmr_value, 0);
    ext_pin = 1'b0; step(30);
    chk("R6 falling edge counted", tmr_value, 1);
    wr_opt(8'h20); step(20);
    wr_tmr(8'd0); step(20);
    pin_pulses(4);
    chk("R6 pin through 1:2 prescaler", tmr_value, 2);
  endtask

  task automatic t_wdog();
    int base;
    wr_opt(8'h00); wd_clear();
    base = rst_seen; wd_ticks(255);
    chk("R8 no reset before 256", rst_seen - base, 0);
    wd_ticks(1);
    chk("R8 reset at 256 one clock", rst_seen - base, 1);
    wr_opt(8'h09); wd_clear();
    base = rst_seen; wd_ticks(511);
    chk("R8 no reset before 512", rst_seen - base, 0);
    wd_ticks(1);
    chk("R8 reset at 512", rst_seen - base, 1);
    wd_clear();
    base = rst_seen; wd_ticks(256);
    wd_clear(); wd_ticks(256);
    chk("R9 clear empties prescaler", rst_seen - base, 0);
    wd_ticks(256);
    chk("R9 period after clear", rst_seen - base, 1);
  endtask

  task automatic t_switch();
    int base;
    wr_opt(8'h07); wd_clear();
    wr_tmr(8'd0); step(4 * 33);
    sleep = 1'b1;
    wr_opt(8'h0D);
    base = rst_seen; wd_ticks(256);
    chk("R10 early reset after unsafe switch", rst_seen - base, 1);
    sleep = 1'b0;
    wr_opt(8'h07); wd_clear();
    wr_tmr(8'd0); step(4 * 33);
    wr_tmr(8'd0);
    sleep = 1'b1;
    wr_opt(8'h0D);
    base = rst_seen; wd_ticks(256);
    chk("R10 no early reset after clearing", rst_seen - base, 0);
    sleep = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tmr_wr = 0; opt_wr = 0; ovf_clr = 0; ovf_ie = 0;
    ext_pin = 1'b1; sleep = 0; wdt_tick = 0; wdt_clr = 0;
    tmr_wdata = 0; opt_wdata = 0;
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_cycle_count();
    t_ratio();
    t_flag();
    t_sleep();
    t_pin();
    t_wdog();
    t_switch();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL all requirements: run hung act=timeout exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule